// File: doc/BRIEF.md
# Complementary Dead-Time Output Stage

This block sits between a PWM timebase and a pair of output pins. It takes two raw compare signals, A and B, and turns them into the two final pin levels and their output enables. In independent mode each pin follows its own signal. In complementary mode one signal, A or B, is the single source. The A pin carries that source and the B pin carries its inverse. A dead time, programmed separately for each pin, is inserted before either pin turns active, so the two pins are never active together.

Ahead of the pair logic, each channel has a force multiplexer. It can replace the raw compare signal with its inverse, with a software level, or with an external level. The new choice is applied only when a force event occurs. The force event comes either from a local software strobe or from an external trigger, as one control pin selects. After the dead-time logic, each pin has its own polarity inversion, and a fault input drives both pins to their inactive level at once.

There is no data stream in this block. Every pin is a plain control or status level, so there is no valid/ready handshake and no back-pressure.

Top module: `cdt_output_stage`

## Requirements
- R1: With `indep_mode`=1, the active level of pin A follows the A path and pin B follows the B path, each one clock edge after its input, with no dead time.
- R2: With `indep_mode`=0, the source is the B path when `pair_src_b`=1 and the A path otherwise. Pin A's active level is the source and pin B's is its inverse; the signal that is not the source has no effect.
- R3: In complementary mode, pin A turns active on the (1+`dt_cnt_a`)th clock edge at which the source has been high without a break. Pin B turns active on the (1+`dt_cnt_b`)th edge at which the source has been low without a break. A count of 0 gives one edge.
- R4: A pin turns inactive on the first clock edge at which its request drops. In complementary mode, pin A and pin B are never active at the same time.
- R5: Each pin equals its active level XOR its polarity bit (`pol_inv_a`, `pol_inv_b`); a set bit makes the pin active-low.
- R6: `pwm_a_oe` follows `oe_a` and `pwm_b_oe` follows `oe_b`; a 0 releases the pin.
- R7: While `fault_kill`=1, both pins sit at their inactive level (pin value equals its polarity bit), within the same cycle and with no clock edge needed.
- R8: The force-source code of each channel selects 00 = raw signal, 01 = inverted raw signal, 10 = `sw_level_x`, 11 = `ext_level_x`. The code is loaded only on a force event and is 00 after reset. Its effect reaches the pin one edge after the loading edge.
- R9: With `force_from_ext`=0, only `force_strobe_sw` makes a force event. With `force_from_ext`=1, only `force_trig_ext` does; the other input is ignored.
- R10: After reset, both active levels are 0, so each pin equals its polarity bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| raw_a | input | 1 | Raw compare signal A |
| raw_b | input | 1 | Raw compare signal B |
| indep_mode | input | 1 | 1 = independent pins, 0 = complementary pair |
| pair_src_b | input | 1 | Complementary source: 1 = B path, 0 = A path |
| dt_cnt_a | input | DT_W | Dead-time count before pin A turns active |
| dt_cnt_b | input | DT_W | Dead-time count before pin B turns active |
| pol_inv_a | input | 1 | Pin A active-low when 1 |
| pol_inv_b | input | 1 | Pin B active-low when 1 |
| oe_a | input | 1 | Pin A output enable |
| oe_b | input | 1 | Pin B output enable |
| force_sel_a | input | 2 | Force-source code for channel A |
| force_sel_b | input | 2 | Force-source code for channel B |
| sw_level_a | input | 1 | Software level for channel A |
| sw_level_b | input | 1 | Software level for channel B |
| ext_level_a | input | 1 | External level for channel A |
| ext_level_b | input | 1 | External level for channel B |
| force_from_ext | input | 1 | Force event source: 1 = external trigger, 0 = software strobe |
| force_strobe_sw | input | 1 | Software force strobe |
| force_trig_ext | input | 1 | External force trigger |
| fault_kill | input | 1 | Drives both pins to inactive while high |
| pwm_a_o | output | 1 | Pin A level |
| pwm_b_o | output | 1 | Pin B level |
| pwm_a_oe | output | 1 | Pin A output enable |
| pwm_b_oe | output | 1 | Pin B output enable |

## Verification
The assertions check four things on every cycle:
- In complementary mode, the two active levels are never both high.
- A dropped request clears its pin on the next edge.
- A pin only turns active after a cycle in which its request was present.
- The force-source code holds between force events, and the pins stay inactive while the fault input is high.

The exact dead-time lengths, the selection of the complementary source, the meaning of each force code and the routing of the force trigger depend on the counts and the stimulus, so only the bench's timed scenarios can show them.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
  localparam int NCH = 2;
  typedef enum logic [1:0] {
    FSRC_PWM   = 2'b00,
    FSRC_INV   = 2'b01,
    FSRC_SWLVL = 2'b10,
    FSRC_EXT   = 2'b11
  } fsrc_e;
endpackage

// File: rtl/cdt_force_sel.sv
module cdt_force_sel
  import cdt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [1:0] sel_in,
  input  logic       raw,
  input  logic       sw_lvl,
  input  logic       ext_lvl,
  output logic       sig_o
);
  fsrc_e sel_q;

  // active code is only replaced on a force event
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    sel_q <= FSRC_PWM;
    else if (load) sel_q <= fsrc_e'(sel_in);
  end

  always_comb begin
    unique case (sel_q)
      FSRC_PWM:   sig_o = raw;
      FSRC_INV:   sig_o = ~raw;
      FSRC_SWLVL: sig_o = sw_lvl;
      FSRC_EXT:   sig_o = ext_lvl;
      default:    sig_o = raw;
    endcase
  end

  p_sel_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(sel_q));
endmodule

// File: rtl/cdt_pair_steer.sv
module cdt_pair_steer
  import cdt_pkg::*;
(
  input  logic           indep,
  input  logic           src_b,
  input  logic [NCH-1:0] sig,
  output logic [NCH-1:0] want
);
  logic src;

  always_comb begin
    src = src_b ? sig[1] : sig[0];
    if (indep) want = sig;
    else       want = {~src, src};
  end
endmodule

// File: rtl/cdt_deadband.sv
module cdt_deadband #(
  parameter int DT_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            want,
  input  logic [DT_W-1:0] dt,
  output logic            act_o
);
  logic [DT_W-1:0] dwell_q;

  // counter stops at dt, so it cannot wrap
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dwell_q <= '0;
      act_o   <= 1'b0;
    end else if (!want) begin
      dwell_q <= '0;
      act_o   <= 1'b0;
    end else if (dwell_q >= dt) begin
      act_o   <= 1'b1;
    end else begin
      dwell_q <= dwell_q + 1'b1;
    end
  end

  p_fall_fast_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !want |=> !act_o);
  p_rise_after_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(act_o) |-> $past(want));
endmodule

// File: rtl/cdt_output_stage.sv
module cdt_output_stage
  import cdt_pkg::*;
#(
  parameter int DT_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            raw_a,
  input  logic            raw_b,
  input  logic            indep_mode,
  input  logic            pair_src_b,
  input  logic [DT_W-1:0] dt_cnt_a,
  input  logic [DT_W-1:0] dt_cnt_b,
  input  logic            pol_inv_a,
  input  logic            pol_inv_b,
  input  logic            oe_a,
  input  logic            oe_b,
  input  logic [1:0]      force_sel_a,
  input  logic [1:0]      force_sel_b,
  input  logic            sw_level_a,
  input  logic            sw_level_b,
  input  logic            ext_level_a,
  input  logic            ext_level_b,
  input  logic            force_from_ext,
  input  logic            force_strobe_sw,
  input  logic            force_trig_ext,
  input  logic            fault_kill,
  output logic            pwm_a_o,
  output logic            pwm_b_o,
  output logic            pwm_a_oe,
  output logic            pwm_b_oe
);
  logic [1:0]      fsel   [NCH];
  logic            raw_v  [NCH];
  logic            sw_v   [NCH];
  logic            ext_v  [NCH];
  logic [DT_W-1:0] dt_v   [NCH];
  logic [NCH-1:0]  forced;
  logic [NCH-1:0]  want;
  logic [NCH-1:0]  act;
  logic            force_evt;

  assign fsel[0]  = force_sel_a;  assign fsel[1]  = force_sel_b;
  assign raw_v[0] = raw_a;        assign raw_v[1] = raw_b;
  assign sw_v[0]  = sw_level_a;   assign sw_v[1]  = sw_level_b;
  assign ext_v[0] = ext_level_a;  assign ext_v[1] = ext_level_b;
  assign dt_v[0]  = dt_cnt_a;     assign dt_v[1]  = dt_cnt_b;

  assign force_evt = force_from_ext ? force_trig_ext : force_strobe_sw;

  for (genvar c = 0; c < NCH; c++) begin : g_fsel
    cdt_force_sel u_fsel (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (force_evt),
      .sel_in  (fsel[c]),
      .raw     (raw_v[c]),
      .sw_lvl  (sw_v[c]),
      .ext_lvl (ext_v[c]),
      .sig_o   (forced[c])
    );
  end

  cdt_pair_steer u_steer (
    .indep (indep_mode),
    .src_b (pair_src_b),
    .sig   (forced),
    .want  (want)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_db
    logic [DT_W-1:0] dt_eff;
    assign dt_eff = indep_mode ? '0 : dt_v[c];
    cdt_deadband #(.DT_W(DT_W)) u_db (
      .clk   (clk),
      .rst_n (rst_n),
      .want  (want[c]),
      .dt    (dt_eff),
      .act_o (act[c])
    );
  end

  // fault path is combinational so it acts without waiting for an edge
  assign pwm_a_o  = (act[0] & ~fault_kill) ^ pol_inv_a;
  assign pwm_b_o  = (act[1] & ~fault_kill) ^ pol_inv_b;
  assign pwm_a_oe = oe_a;
  assign pwm_b_oe = oe_b;

  p_fault_safe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fault_kill |-> (pwm_a_o == pol_inv_a) && (pwm_b_o == pol_inv_b));
  p_no_overlap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(indep_mode) |-> !(act[0] && act[1]));
endmodule

// File: tb/cdt_output_stage_test.sv
module cdt_output_stage_test;
  localparam int PERIOD = 10;
  localparam int DT_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic raw_a = 0, raw_b = 0, indep_mode = 1, pair_src_b = 0;
  logic [DT_W-1:0] dt_cnt_a = 1, dt_cnt_b = 1;
  logic pol_inv_a = 0, pol_inv_b = 0, oe_a = 1, oe_b = 1;
  logic [1:0] force_sel_a = 0, force_sel_b = 0;
  logic sw_level_a = 0, sw_level_b = 0, ext_level_a = 0, ext_level_b = 0;
  logic force_from_ext = 0, force_strobe_sw = 0, force_trig_ext = 0, fault_kill = 0;
  logic pwm_a_o, pwm_b_o, pwm_a_oe, pwm_b_oe;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  cdt_output_stage #(.DT_W(DT_W)) uut (.*);

  // bits: indep srcb pola polb oea oeb fault ra rb | exp_a exp_b
  localparam logic [10:0] VEC [10] = '{
    11'b10001101010, 11'b10001100101, 11'b10101101101, 11'b00001101010,
    11'b00001100101, 11'b01001100110, 11'b01001101001, 11'b10001111100,
    11'b10111111111, 11'b10000001010
  };
  localparam string VREQ [10] = '{"R1", "R1", "R5", "R2", "R2", "R2", "R2",
                                  "R7", "R7", "R6"};

  task automatic step(int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic chk(string req, logic [3:0] got, logic [3:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  task automatic pins(string req, logic ea, logic eb);
    chk(req, {2'b00, pwm_a_o, pwm_b_o}, {2'b00, ea, eb});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(PERIOD * 20000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    // R10 reset state
    @(negedge clk);
    pins("R10", 1'b0, 1'b0);
    rst_n = 1;
    step(2);
    pins("R10", 1'b0, 1'b0);

    // table of steady-state patterns
    for (int i = 0; i < 10; i++) begin
      {indep_mode, pair_src_b, pol_inv_a, pol_inv_b, oe_a, oe_b,
       fault_kill, raw_a, raw_b} = VEC[i][10:2];
      step(6);
      chk(VREQ[i], {pwm_a_o, pwm_b_o, pwm_a_oe, pwm_b_oe},
          {VEC[i][1:0], VEC[i][6:5]});
    end
    {fault_kill, pol_inv_a, pol_inv_b, oe_a, oe_b} = 5'b00011;

    // R3 / R4 dead-time timing, complementary source A
    indep_mode = 0; pair_src_b = 0; dt_cnt_a = 3; dt_cnt_b = 2;
    raw_a = 0; raw_b = 1;
    step(8);
    pins("R3", 1'b0, 1'b1);
    raw_a = 1;
    step(1);
    pins("R4", 1'b0, 1'b0);
    step(2);
    pins("R3", 1'b0, 1'b0);
    step(1);
    pins("R3", 1'b1, 1'b0);
    raw_a = 0;
    step(1);
    pins("R4", 1'b0, 1'b0);
    step(1);
    pins("R3", 1'b0, 1'b0);
    step(1);
    pins("R3", 1'b0, 1'b1);
    dt_cnt_a = 0;
    raw_a = 1;
    step(1);
    pins("R3", 1'b1, 1'b0);

    // R2: source B, A path has no effect
    pair_src_b = 1; raw_b = 0;
    step(6);
    raw_a = 0;
    step(3);
    pins("R2", 1'b0, 1'b1);

    // R8 / R9 force selection
    indep_mode = 1; raw_a = 0; raw_b = 0;
    force_sel_a = 2'b10; sw_level_a = 1;
    step(4);
    pins("R8", 1'b0, 1'b0);
    force_strobe_sw = 1;
    step(1);
    force_strobe_sw = 0;
    pins("R8", 1'b0, 1'b0);
    step(1);
    pins("R8", 1'b1, 1'b0);
    force_sel_b = 2'b01;
    force_trig_ext = 1;
    step(1);
    force_trig_ext = 0;
    step(3);
    pins("R9", 1'b1, 1'b0);
    force_from_ext = 1;
    force_trig_ext = 1;
    step(1);
    force_trig_ext = 0;
    step(1);
    pins("R9", 1'b1, 1'b1);
    force_sel_a = 2'b00;
    force_strobe_sw = 1;
    step(1);
    force_strobe_sw = 0;
    step(3);
    pins("R9", 1'b1, 1'b1);
    force_sel_b = 2'b11; ext_level_b = 0;
    force_trig_ext = 1;
    step(1);
    force_trig_ext = 0;
    step(1);
    pins("R8", 1'b0, 1'b0);
    ext_level_b = 1;
    step(2);
    pins("R8", 1'b0, 1'b1);

    // R7 fault acts within the cycle
    fault_kill = 1;
    #1;
    pins("R7", 1'b0, 1'b0);
    pol_inv_b = 1;
    #1;
    pins("R7", 1'b0, 1'b1);
    fault_kill = 0;
    #1;
    pins("R5", 1'b0, 1'b0);
    step(2);
    finish_run();
  end
endmodule